// File: doc/BRIEF.md
# Adaptive Partial-Program Time Scheduler

This block sits inside a flash controller and, for every page write, decides whether the page gets a full program or a partial program. For a partial program it also returns the time after which the write is cut. Time is counted in clock cycles. The block learns nominal program times from designated pages, and the controller reports each measured full-program time back to it. A partial time is the learned time minus a configurable number of skipped program-verify loops. The cut then falls at the end of a program pulse.

A block of flash is treated as `LAYERS` layers of `PAGES` pages. In single-bit (lower-page) mode, page 1 of each layer teaches the time for that layer. Page 0 of every layer is slow, and it uses a block-wide time that page 0 of layer 0 teaches. In upper-page mode, page 0 of each layer teaches that layer's upper-page time. The controller issues a request and gets an answer one cycle later. It sends a measurement whenever a full program completes. It pulses an erase input when the physical block is erased, which discards everything learned.

Top module: `pps_sched`

## Requirements
- R1: While reset is applied, `rsp_valid` is 0. After reset, and after any erase, no learned time is valid, so every request is answered with a full program.
- R2: A request accepted at clock edge k is answered at edge k+1, with `rsp_valid` high for exactly that one cycle. `rsp_valid` is low in every cycle that follows a cycle without a request.
- R3: A lower-page request (`req_msb`=0) with index 1 always gets a full program. A measurement for that page stores its time as the learned lower-page time of its layer.
- R4: A lower-page request with index 2 or above uses the lower-page time learned for its own layer. If no time has been learned for that layer, it gets a full program.
- R5: A lower-page request with index 0 in layer 0 always gets a full program, and its measurement becomes the block-wide slow-page time. A lower-page request with index 0 in any other layer uses the slow-page time, or gets a full program if that time is not yet learned.
- R6: An upper-page request (`req_msb`=1) with index 0 always gets a full program, and its measurement becomes that layer's upper-page time. Upper-page requests with other indices use that time.
- R7: A partial answer has `rsp_partial`=1 and `rsp_time` = learned − (`cfg_nskip`+1)·`cfg_tpcy` + `cfg_tpsu` + `cfg_tp`.
- R8: A full-program answer has `rsp_partial`=0 and `rsp_time`=0. The block gives a full program instead of a partial one when the formula of R7 gives 0 or less, or gives a value not below the learned time.
- R9: A measurement for a page that is not a learning page (any case not named in R3, R5 or R6 as a source) changes no learned time.
- R10: `erase` clears all learned times in the cycle it is high. A measurement in the same cycle is dropped. A request in the same cycle gets a full program.
- R11: A request whose learned entry is written by a measurement in the same cycle uses the newly measured time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Write request present |
| req_layer | input | LAYER_W | Layer of the target page |
| req_index | input | IDX_W | Page index within the layer |
| req_msb | input | 1 | 1 = upper-page mode, 0 = lower-page/single-bit mode |
| meas_valid | input | 1 | Measured full-program time present |
| meas_layer | input | LAYER_W | Layer of the measured page |
| meas_index | input | IDX_W | Index of the measured page |
| meas_msb | input | 1 | Mode of the measured page |
| meas_time | input | TIME_W | Measured program time in cycles |
| erase | input | 1 | Block erased: drop all learned times |
| cfg_nskip | input | NSKIP_W | Number of program-verify loops to skip |
| cfg_tpcy | input | TIME_W | Cycles per program-verify loop |
| cfg_tpsu | input | TIME_W | Pulse setup cycles |
| cfg_tp | input | TIME_W | Pulse cycles |
| rsp_valid | output | 1 | Answer present |
| rsp_partial | output | 1 | 1 = partial program, 0 = full program |
| rsp_time | output | TIME_W | Partial program time, 0 for a full program |

## Verification
A measurement update and a request lookup can fall in the same cycle. So can an erase and either of these. The bench provokes these collisions on purpose. It drives a learning-page measurement together with a request whose lookup hits the entry being written. It also drives an erase together with a measurement and with a request. The expected answers are the forwarded new time for the first case and a full program for the erase cases. Afterwards, further requests show what the tables kept: the dropped measurement must leave no trace. A behavioural model runs through the long random phase too. There, collisions arise at random, and the model judges every answer as it comes.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  typedef enum logic [1:0] {
    TBL_NONE = 2'd0,
    TBL_SLOW = 2'd1,
    TBL_LSB  = 2'd2,
    TBL_MSB  = 2'd3
  } tbl_sel_e;

  localparam int unsigned SLOW_PAGE_IDX  = 0;
  localparam int unsigned LSB_LEARN_IDX  = 1;
  localparam int unsigned MSB_LEARN_IDX  = 0;
  localparam int unsigned SLOW_SRC_LAYER = 0;
endpackage

// File: rtl/pps_page_class.sv
`timescale 1ns/1ps
module pps_page_class
  import pps_pkg::*;
#(
  parameter int unsigned LAYER_W = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [LAYER_W-1:0] layer,
  input  logic [IDX_W-1:0]   index,
  input  logic               msb,
  output tbl_sel_e           tbl,
  output logic               learn
);
  always_comb begin
    tbl   = TBL_NONE;
    learn = 1'b0;
    if (msb) begin
      tbl   = TBL_MSB;
      learn = (index == IDX_W'(MSB_LEARN_IDX));
    end else if (index == IDX_W'(SLOW_PAGE_IDX)) begin
      tbl   = TBL_SLOW;
      learn = (layer == LAYER_W'(SLOW_SRC_LAYER));
    end else begin
      tbl   = TBL_LSB;
      learn = (index == IDX_W'(LSB_LEARN_IDX));
    end
  end
endmodule

// File: rtl/pps_entry.sv
`timescale 1ns/1ps
module pps_entry #(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [TIME_W-1:0] din,
  output logic [TIME_W-1:0] q,
  output logic              vld
);
  logic vld_d;

  always_comb begin
    vld_d = vld;
    if (clear)     vld_d = 1'b0;
    else if (load) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) q <= din;
  end
endmodule

// File: rtl/pps_learn_store.sv
`timescale 1ns/1ps
module pps_learn_store
  import pps_pkg::*;
#(
  parameter int unsigned LAYERS = 32,
  parameter int unsigned TIME_W = 16,
  localparam int unsigned LAYER_W = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase,
  input  logic               wr_en,
  input  tbl_sel_e           wr_tbl,
  input  logic [LAYER_W-1:0] wr_layer,
  input  logic [TIME_W-1:0]  wr_time,
  input  tbl_sel_e           rd_tbl,
  input  logic [LAYER_W-1:0] rd_layer,
  output logic [TIME_W-1:0]  rd_time,
  output logic               rd_vld
);
  logic [LAYERS*TIME_W-1:0] lsb_flat, msb_flat;
  logic [LAYERS-1:0]        lsb_vld, msb_vld;
  logic [TIME_W-1:0]        slow_time;
  logic                     slow_vld;
  logic                     wr_ok;

  assign wr_ok = wr_en && !erase;

  for (genvar g = 0; g < LAYERS; g++) begin : g_layer
    logic ld_lsb, ld_msb;
    assign ld_lsb = wr_ok && (wr_tbl == TBL_LSB) && (wr_layer == LAYER_W'(g));
    assign ld_msb = wr_ok && (wr_tbl == TBL_MSB) && (wr_layer == LAYER_W'(g));

    pps_entry #(.TIME_W(TIME_W)) i_lsb (
      .clk(clk), .rst_n(rst_n), .clear(erase), .load(ld_lsb), .din(wr_time),
      .q(lsb_flat[g*TIME_W +: TIME_W]), .vld(lsb_vld[g])
    );
    pps_entry #(.TIME_W(TIME_W)) i_msb (
      .clk(clk), .rst_n(rst_n), .clear(erase), .load(ld_msb), .din(wr_time),
      .q(msb_flat[g*TIME_W +: TIME_W]), .vld(msb_vld[g])
    );
  end

  pps_entry #(.TIME_W(TIME_W)) i_slow (
    .clk(clk), .rst_n(rst_n), .clear(erase),
    .load(wr_ok && (wr_tbl == TBL_SLOW)), .din(wr_time),
    .q(slow_time), .vld(slow_vld)
  );

  logic hit;
  always_comb begin
    hit = wr_en && (wr_tbl == rd_tbl) && (rd_tbl != TBL_NONE) &&
          ((rd_tbl == TBL_SLOW) || (wr_layer == rd_layer));
    unique case (rd_tbl)
      TBL_SLOW: begin rd_time = slow_time;                           rd_vld = slow_vld;          end
      TBL_LSB:  begin rd_time = lsb_flat[rd_layer*TIME_W +: TIME_W]; rd_vld = lsb_vld[rd_layer]; end
      TBL_MSB:  begin rd_time = msb_flat[rd_layer*TIME_W +: TIME_W]; rd_vld = msb_vld[rd_layer]; end
      default:  begin rd_time = '0;                                  rd_vld = 1'b0;              end
    endcase
    if (erase) begin
      rd_vld = 1'b0;
    end else if (hit) begin
      rd_time = wr_time;
      rd_vld  = 1'b1;
    end
  end

  p_erase_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lsb_vld == '0) && (msb_vld == '0) && !slow_vld);

  p_load_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase && wr_tbl == TBL_LSB) |=> lsb_vld[$past(wr_layer)]);

  p_slow_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase && wr_tbl == TBL_SLOW) |=> (slow_vld && slow_time == $past(wr_time)));
endmodule

// File: rtl/pps_ptime_calc.sv
`timescale 1ns/1ps
module pps_ptime_calc #(
  parameter int unsigned TIME_W  = 16,
  parameter int unsigned NSKIP_W = 3,
  localparam int unsigned SUM_W  = TIME_W + NSKIP_W + 3
) (
  input  logic [TIME_W-1:0]  learned,
  input  logic               use_ok,
  input  logic [NSKIP_W-1:0] nskip,
  input  logic [TIME_W-1:0]  tpcy,
  input  logic [TIME_W-1:0]  tpsu,
  input  logic [TIME_W-1:0]  tp,
  output logic               partial,
  output logic [TIME_W-1:0]  ptime
);
  logic [SUM_W-1:0] loops, cut, gain, base, diff;

  always_comb begin
    loops   = SUM_W'(nskip) + SUM_W'(1);
    cut     = loops * SUM_W'(tpcy);
    gain    = SUM_W'(tpsu) + SUM_W'(tp);
    base    = SUM_W'(learned) + gain;
    diff    = base - cut;
    partial = use_ok && (base > cut) && (gain < cut);
    ptime   = partial ? diff[TIME_W-1:0] : '0;
  end
endmodule

// File: rtl/pps_sched.sv
`timescale 1ns/1ps
module pps_sched
  import pps_pkg::*;
#(
  parameter int unsigned LAYERS  = 32,
  parameter int unsigned PAGES   = 16,
  parameter int unsigned TIME_W  = 16,
  parameter int unsigned NSKIP_W = 3,
  localparam int unsigned LAYER_W = (LAYERS > 1) ? $clog2(LAYERS) : 1,
  localparam int unsigned IDX_W   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LAYER_W-1:0] req_layer,
  input  logic [IDX_W-1:0]   req_index,
  input  logic               req_msb,
  input  logic               meas_valid,
  input  logic [LAYER_W-1:0] meas_layer,
  input  logic [IDX_W-1:0]   meas_index,
  input  logic               meas_msb,
  input  logic [TIME_W-1:0]  meas_time,
  input  logic               erase,
  input  logic [NSKIP_W-1:0] cfg_nskip,
  input  logic [TIME_W-1:0]  cfg_tpcy,
  input  logic [TIME_W-1:0]  cfg_tpsu,
  input  logic [TIME_W-1:0]  cfg_tp,
  output logic               rsp_valid,
  output logic               rsp_partial,
  output logic [TIME_W-1:0]  rsp_time
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  tbl_sel_e req_tbl, meas_tbl;
  logic     req_learn, meas_learn;

  pps_page_class #(.LAYER_W(LAYER_W), .IDX_W(IDX_W)) i_req_cls (
    .layer(req_layer), .index(req_index), .msb(req_msb),
    .tbl(req_tbl), .learn(req_learn)
  );
  pps_page_class #(.LAYER_W(LAYER_W), .IDX_W(IDX_W)) i_meas_cls (
    .layer(meas_layer), .index(meas_index), .msb(meas_msb),
    .tbl(meas_tbl), .learn(meas_learn)
  );

  logic [TIME_W-1:0] lrn_time;
  logic              lrn_vld;

  pps_learn_store #(.LAYERS(LAYERS), .TIME_W(TIME_W)) i_store (
    .clk(clk), .rst_n(rst_i_n), .erase(erase),
    .wr_en(meas_valid && meas_learn), .wr_tbl(meas_tbl),
    .wr_layer(meas_layer), .wr_time(meas_time),
    .rd_tbl(req_tbl), .rd_layer(req_layer),
    .rd_time(lrn_time), .rd_vld(lrn_vld)
  );

  logic              calc_partial;
  logic [TIME_W-1:0] calc_time;

  pps_ptime_calc #(.TIME_W(TIME_W), .NSKIP_W(NSKIP_W)) i_calc (
    .learned(lrn_time), .use_ok(lrn_vld && !req_learn),
    .nskip(cfg_nskip), .tpcy(cfg_tpcy), .tpsu(cfg_tpsu), .tp(cfg_tp),
    .partial(calc_partial), .ptime(calc_time)
  );

  logic rsp_valid_d;
  assign rsp_valid_d = req_valid;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rsp_valid <= 1'b0;
    else          rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_partial <= calc_partial;
      rsp_time    <= calc_time;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |=> !rsp_valid);
  p_lsb_learn_full_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && !req_msb && req_index == IDX_W'(LSB_LEARN_IDX)) |=> !rsp_partial);
  p_msb_learn_full_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_msb && req_index == IDX_W'(MSB_LEARN_IDX)) |=> !rsp_partial);
  p_partial_shorter_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && calc_partial) |=> (rsp_partial && rsp_time < $past(lrn_time) && rsp_time != '0));
  p_full_zero_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && !rsp_partial) |-> (rsp_time == '0));
  p_erase_full_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && erase) |=> !rsp_partial);
endmodule

// File: tb/test_pps_sched.sv
`timescale 1ns/1ps
module test_pps_sched;
  localparam int LAYERS = 32;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_msb, meas_valid, meas_msb, erase;
  logic [4:0] req_layer, meas_layer;
  logic [3:0] req_index, meas_index;
  logic [TW-1:0] meas_time, cfg_tpcy, cfg_tpsu, cfg_tp;
  logic [2:0] cfg_nskip;
  logic rsp_valid, rsp_partial;
  logic [TW-1:0] rsp_time;

  always #2.5 clk = ~clk;

  pps_sched i_pps_sched (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_layer(req_layer), .req_index(req_index), .req_msb(req_msb),
    .meas_valid(meas_valid), .meas_layer(meas_layer), .meas_index(meas_index),
    .meas_msb(meas_msb), .meas_time(meas_time), .erase(erase),
    .cfg_nskip(cfg_nskip), .cfg_tpcy(cfg_tpcy), .cfg_tpsu(cfg_tpsu), .cfg_tp(cfg_tp),
    .rsp_valid(rsp_valid), .rsp_partial(rsp_partial), .rsp_time(rsp_time)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;

  // behavioural reference: kinds 0 slow source, 1 slow user, 2 lower learn,
  // 3 lower user, 4 upper learn, 5 upper user
  int  m_lsb_t[LAYERS];
  bit  m_lsb_v[LAYERS];
  int  m_msb_t[LAYERS];
  bit  m_msb_v[LAYERS];
  int  m_slow_t;
  bit  m_slow_v;
  bit  exp_v, exp_p;
  int  exp_t;
  string exp_tag;

  function automatic int kind_of(int layer, int idx, bit msb);
    if (msb) return (idx == 0) ? 4 : 5;
    if (idx == 0) return (layer == 0) ? 0 : 1;
    return (idx == 1) ? 2 : 3;
  endfunction

  function automatic bit is_learn(int k);
    return (k == 0) || (k == 2) || (k == 4);
  endfunction

  function automatic int table_of(int k);
    return (k <= 1) ? 0 : ((k <= 3) ? 1 : 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LAYERS; i++) begin m_lsb_v[i] = 0; m_msb_v[i] = 0; end
      m_slow_v = 0;
      exp_v = 0;
    end else begin
      int rk, mk, lt, val;
      bit lv;
      rk = kind_of(req_layer, req_index, req_msb);
      mk = kind_of(meas_layer, meas_index, meas_msb);
      exp_v = req_valid;
      if (req_valid) begin
        case (table_of(rk))
          0: begin lt = m_slow_t; lv = m_slow_v; end
          1: begin lt = m_lsb_t[req_layer]; lv = m_lsb_v[req_layer]; end
          default: begin lt = m_msb_t[req_layer]; lv = m_msb_v[req_layer]; end
        endcase
        exp_tag = (rk <= 1) ? "R5" : (rk == 2) ? "R3" : (rk == 3) ? "R4" : "R6";
        if (meas_valid && is_learn(mk) && table_of(mk) == table_of(rk) &&
            (table_of(rk) == 0 || meas_layer == req_layer)) begin
          lt = meas_time; lv = 1; exp_tag = "R11";
        end
        if (erase) begin lv = 0; exp_tag = "R10"; end
        val = lt - (cfg_nskip + 1) * cfg_tpcy + cfg_tpsu + cfg_tp;
        if (lv && !is_learn(rk) && val > 0 && val < lt) begin
          exp_p = 1; exp_t = val;
          if (exp_tag != "R11") exp_tag = "R7";
        end else begin
          exp_p = 0; exp_t = 0;
          if (lv && !is_learn(rk) && exp_tag != "R11") exp_tag = "R8";
        end
      end
      if (erase) begin
        for (int i = 0; i < LAYERS; i++) begin m_lsb_v[i] = 0; m_msb_v[i] = 0; end
        m_slow_v = 0;
      end else if (meas_valid && is_learn(mk)) begin
        case (table_of(mk))
          0: begin m_slow_t = meas_time; m_slow_v = 1; end
          1: begin m_lsb_t[meas_layer] = meas_time; m_lsb_v[meas_layer] = 1; end
          default: begin m_msb_t[meas_layer] = meas_time; m_msb_v[meas_layer] = 1; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      n_vec++;
      if (rsp_valid !== exp_v) begin
        n_bad++;
        $display("FAIL R2: rsp_valid=%0b expected %0b", rsp_valid, exp_v);
      end else if (exp_v && (rsp_partial !== exp_p || rsp_time !== TW'(exp_t))) begin
        n_bad++;
        $display("FAIL %s: partial/time=%0b/%0d expected %0b/%0d",
                 exp_tag, rsp_partial, rsp_time, exp_p, exp_t);
      end
    end
  end

  task automatic idle();
    req_valid = 0; meas_valid = 0; erase = 0;
  endtask

  task automatic do_meas(input int layer, input int idx, input bit msb, input int t);
    meas_valid = 1; meas_layer = 5'(layer); meas_index = 4'(idx); meas_msb = msb; meas_time = TW'(t);
    @(negedge clk); idle();
  endtask

  task automatic set_req(input int layer, input int idx, input bit msb);
    req_valid = 1; req_layer = 5'(layer); req_index = 4'(idx); req_msb = msb;
  endtask

  task automatic expect_rsp(input string tag, input bit p, input int t);
    n_vec++;
    if (rsp_valid !== 1'b1 || rsp_partial !== p || rsp_time !== TW'(t)) begin
      n_bad++;
      $display("FAIL %s: valid/partial/time=%0b/%0b/%0d expected 1/%0b/%0d",
               tag, rsp_valid, rsp_partial, rsp_time, p, t);
    end
  endtask

  task automatic req_chk(input string tag, input int layer, input int idx, input bit msb,
                         input bit p, input int t);
    set_req(layer, idx, msb);
    @(negedge clk); idle();
    expect_rsp(tag, p, t);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; idle();
    req_layer = 0; req_index = 0; req_msb = 0;
    meas_layer = 0; meas_index = 0; meas_msb = 0; meas_time = 0;
    cfg_nskip = 3'd2; cfg_tpcy = 16'd40; cfg_tpsu = 16'd6; cfg_tp = 16'd22;
    repeat (3) @(negedge clk);
    // R1: no answer while reset is held
    n_vec++;
    if (rsp_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_en = 1;

    // R1: nothing learned yet -> full program
    req_chk("R1", 5, 7, 0, 0, 0);
    req_chk("R1", 9, 0, 0, 0, 0);
    do_meas(0, 0, 0, 500);
    do_meas(5, 1, 0, 600);
    do_meas(5, 0, 1, 1000);
    req_chk("R4", 5, 7, 0, 1, 508);   // R7: 600-3*40+28
    req_chk("R5", 9, 0, 0, 1, 408);
    req_chk("R5", 0, 0, 0, 0, 0);
    req_chk("R3", 5, 1, 0, 0, 0);
    req_chk("R6", 5, 9, 1, 1, 908);
    req_chk("R6", 5, 0, 1, 0, 0);
    cfg_nskip = 3'd1;
    req_chk("R7", 5, 15, 0, 1, 548);
    cfg_nskip = 3'd2;
    req_chk("R4", 6, 3, 0, 0, 0);     // layer 6 not learned

    // R9: measurement of a user page is ignored
    do_meas(5, 7, 0, 50);
    do_meas(5, 4, 1, 50);
    req_chk("R9", 5, 7, 0, 1, 508);
    req_chk("R9", 5, 4, 1, 1, 908);

    // R8 boundaries on the computed time
    do_meas(6, 1, 0, 93);
    req_chk("R8", 6, 3, 0, 1, 1);
    do_meas(6, 1, 0, 92);
    req_chk("R8", 6, 3, 0, 0, 0);
    cfg_tpcy = 16'd14; cfg_nskip = 3'd1;   // cut equals gain
    req_chk("R8", 5, 7, 0, 0, 0);
    cfg_tpcy = 16'd15;
    req_chk("R8", 5, 7, 0, 1, 598);
    cfg_tpcy = 16'd40; cfg_nskip = 3'd2;

    // R11: write and lookup of the same entry together
    meas_valid = 1; meas_layer = 7; meas_index = 1; meas_msb = 0; meas_time = 300;
    set_req(7, 4, 0);
    @(negedge clk); idle();
    expect_rsp("R11", 1, 208);
    meas_valid = 1; meas_layer = 0; meas_index = 0; meas_msb = 0; meas_time = 700;
    set_req(20, 0, 0);
    @(negedge clk); idle();
    expect_rsp("R11", 1, 608);

    // R10: erase with a measurement, then erase with a request
    erase = 1; meas_valid = 1; meas_layer = 8; meas_index = 1; meas_msb = 0; meas_time = 400;
    @(negedge clk); idle();
    req_chk("R10", 8, 2, 0, 0, 0);
    req_chk("R10", 5, 7, 0, 0, 0);
    do_meas(5, 1, 0, 600);
    erase = 1; set_req(5, 7, 0);
    @(negedge clk); idle();
    expect_rsp("R10", 0, 0);
    req_chk("R10", 5, 7, 0, 0, 0);

    // random traffic judged by the reference model on every clock
    for (int c = 0; c < 4000; c++) begin
      req_valid  = ($urandom_range(0, 3) != 0);
      req_layer  = 5'($urandom_range(0, 7));
      req_index  = 4'($urandom_range(0, 15));
      req_msb    = ($urandom_range(0, 2) == 0);
      meas_valid = ($urandom_range(0, 2) == 0);
      meas_layer = 5'($urandom_range(0, 7));
      meas_index = 4'($urandom_range(0, 3));
      meas_msb   = ($urandom_range(0, 2) == 0);
      meas_time  = TW'($urandom_range(20, 3000));
      erase      = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 99) == 0) cfg_nskip = 3'($urandom_range(0, 3));
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule